// File: doc/BRIEF.md
# Panel Power Sequencing Controller

This block brings an LCD panel driver chip up and down by replaying fixed scripts of register writes. A small read-only script store inside the block holds two programs: a power-up program of 44 writes with three timed pauses, and a power-down program of 4 writes. The block hands each write to an external serial writer and waits for that writer's completion strobe before it moves on. The writer frames the bytes on the wire and is not part of this block.

A single-cycle enable request starts power-up and a single-cycle disable request starts power-down. The block reports the panel condition as off, initialising, active or error, and it drives a busy flag while a script is running. The pause length is given in microseconds and converted to clock cycles from the clock frequency parameter, so the minimum wait holds at any clock rate. If one of the opening zero commands fails, power-up stops at once. A failure after that point does not stop the script, but the panel ends in the error state.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset the panel state is off (`pnl_state` = 0), `busy` is low and `wr_valid` is low.
- R2: Power-up opens with three command-only writes (`wr_kind` = 0) of register 0x00. After the completion strobe of each of these writes, at least DLY_CYC = (CLK_HZ/1e6)·DELAY_US clock cycles pass before the next write request.
- R3: A failure reported on any of the three opening writes ends the script at once. No further write is requested and the panel state becomes error (3).
- R4: After the opening writes, the power-up writes come in this order: one-byte (`wr_kind` = 1, byte in `wr_data[7:0]`) 0xB0←0x17, 0xBC←0x80, 0x3B←0x00, 0xB0←0x16, then a two-byte write (`wr_kind` = 2, `wr_data[15:0]`, high byte sent first) 0xB8←0xFFF9, then the command 0x11.
- R5: Power-up issues exactly 44 writes. The last one is the command 0x29. With no failure reported, the panel state ends as active (2).
- R6: A failure on any write after the opening three does not stop the script. All 44 writes are still issued, and the final state is error (3).
- R7: Power-down issues the command 0x28, then the two-byte write 0xB8←0x8002, then the command 0x10, then the one-byte write 0xB0←0x00. It ends in the off state.
- R8: An enable request while active, a disable request while off, and any request while `busy` is high are all ignored: no write is issued and the state does not change.
- R9: Only one write is outstanding at a time. Its kind, register and data are held steady from the rise of `wr_valid` until `wr_done`, and the next request is raised only after that strobe.
- R10: During power-up the panel state is initialising (1) and `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en_req | input | 1 | One-cycle request to power the panel up |
| dis_req | input | 1 | One-cycle request to power the panel down |
| wr_done | input | 1 | One-cycle completion strobe from the serial writer |
| wr_err | input | 1 | Failure flag, sampled together with `wr_done` |
| wr_valid | output | 1 | A write request is pending |
| wr_kind | output | 2 | 0 command only, 1 one data byte, 2 two data bytes |
| wr_reg | output | 8 | Register or command code |
| wr_data | output | 16 | Data: one byte in [7:0], or two bytes with the high byte sent first |
| busy | output | 1 | A script is running |
| pnl_state | output | 2 | 0 off, 1 initialising, 2 active, 3 error |

## Verification
The assertions assume the writer raises `wr_done` for exactly one cycle, and only while a request is pending. They also assume `wr_err` is meaningful only together with `wr_done`, and that each request is a single-cycle pulse. The bench's writer model answers only a pending request, after a fixed latency, and clears both strobes on the following cycle. Every enable and disable request in the bench is driven for one cycle. Failures are injected at chosen write numbers so that the abort path and the accumulate-and-finish path are both reached.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [1:0] {
    PNL_OFF    = 2'd0,
    PNL_INIT   = 2'd1,
    PNL_ACTIVE = 2'd2,
    PNL_ERROR  = 2'd3
  } pnl_state_e;

  typedef enum logic [1:0] {
    WK_CMD = 2'd0,
    WK_ONE = 2'd1,
    WK_TWO = 2'd2
  } wr_kind_e;

  typedef enum logic [2:0] {
    OP_END = 3'd0,
    OP_CMD = 3'd1,
    OP_ONE = 3'd2,
    OP_TWO = 3'd3,
    OP_DLY = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_WR   = 2'd2,
    SQ_DLY  = 2'd3
  } seq_e;

  typedef struct packed {
    op_e         op;
    logic [7:0]  reg_a;
    logic [15:0] val;
  } step_t;

  localparam int ROM_AW     = 6;
  localparam int UP_BASE    = 0;
  localparam int DOWN_BASE  = 48;
  localparam int OPEN_STEPS = 6;

  function automatic step_t mk(op_e o, logic [7:0] r, logic [15:0] v);
    step_t s;
    s.op    = o;
    s.reg_a = r;
    s.val   = v;
    return s;
  endfunction

endpackage

// File: rtl/pps_rom.sv
module pps_rom
  import pps_pkg::*;
#(
  parameter int AW = ROM_AW
)(
  input  logic [AW-1:0] addr,
  output step_t         step
);

  always_comb begin
    case (addr)
      // opening: bare zero commands, each with a pause behind it
      6'd0:  step = mk(OP_CMD, 8'h00, 16'h0000);
      6'd1:  step = mk(OP_DLY, 8'h00, 16'h0000);
      6'd2:  step = mk(OP_CMD, 8'h00, 16'h0000);
      6'd3:  step = mk(OP_DLY, 8'h00, 16'h0000);
      6'd4:  step = mk(OP_CMD, 8'h00, 16'h0000);
      6'd5:  step = mk(OP_DLY, 8'h00, 16'h0000);
      // standby exit, supplies, sleep exit
      6'd6:  step = mk(OP_ONE, 8'hB0, 16'h0017);
      6'd7:  step = mk(OP_ONE, 8'hBC, 16'h0080);
      6'd8:  step = mk(OP_ONE, 8'h3B, 16'h0000);
      6'd9:  step = mk(OP_ONE, 8'hB0, 16'h0016);
      6'd10: step = mk(OP_TWO, 8'hB8, 16'hFFF9);
      6'd11: step = mk(OP_CMD, 8'h11, 16'h0000);
      // bulk configuration load
      6'd12: step = mk(OP_ONE, 8'hBA, 16'h0001);
      6'd13: step = mk(OP_ONE, 8'hBB, 16'h0000);
      6'd14: step = mk(OP_ONE, 8'h3A, 16'h0060);
      6'd15: step = mk(OP_ONE, 8'hBF, 16'h0010);
      6'd16: step = mk(OP_ONE, 8'hB1, 16'h0056);
      6'd17: step = mk(OP_ONE, 8'hB2, 16'h0033);
      6'd18: step = mk(OP_ONE, 8'hB3, 16'h0011);
      6'd19: step = mk(OP_ONE, 8'hB3, 16'h0011);
      6'd20: step = mk(OP_ONE, 8'hB4, 16'h0002);
      6'd21: step = mk(OP_ONE, 8'hB5, 16'h002B);
      6'd22: step = mk(OP_ONE, 8'hB6, 16'h0040);
      6'd23: step = mk(OP_ONE, 8'hB7, 16'h0003);
      6'd24: step = mk(OP_ONE, 8'hB9, 16'h0004);
      6'd25: step = mk(OP_ONE, 8'hBD, 16'h0004);
      6'd26: step = mk(OP_ONE, 8'hBE, 16'h0000);
      6'd27: step = mk(OP_ONE, 8'hC0, 16'h0011);
      6'd28: step = mk(OP_ONE, 8'hC1, 16'h0011);
      6'd29: step = mk(OP_ONE, 8'hC2, 16'h0011);
      6'd30: step = mk(OP_TWO, 8'hC3, 16'h2040);
      6'd31: step = mk(OP_TWO, 8'hC4, 16'h60C0);
      6'd32: step = mk(OP_TWO, 8'hC5, 16'h1020);
      6'd33: step = mk(OP_TWO, 8'hC6, 16'h60C0);
      6'd34: step = mk(OP_TWO, 8'hC7, 16'h5533);
      6'd35: step = mk(OP_ONE, 8'hC8, 16'h0000);
      6'd36: step = mk(OP_ONE, 8'hC9, 16'h0000);
      6'd37: step = mk(OP_ONE, 8'hCA, 16'h0000);
      6'd38: step = mk(OP_TWO, 8'hEC, 16'h01F0);
      6'd39: step = mk(OP_ONE, 8'hCF, 16'h0002);
      6'd40: step = mk(OP_TWO, 8'hD0, 16'h0804);
      6'd41: step = mk(OP_ONE, 8'hD1, 16'h0001);
      6'd42: step = mk(OP_TWO, 8'hD2, 16'h0000);
      6'd43: step = mk(OP_TWO, 8'hD3, 16'h0D0E);
      6'd44: step = mk(OP_TWO, 8'hD4, 16'h11A4);
      6'd45: step = mk(OP_ONE, 8'hD5, 16'h000E);
      6'd46: step = mk(OP_CMD, 8'h29, 16'h0000);
      // power-down program
      6'd48: step = mk(OP_CMD, 8'h28, 16'h0000);
      6'd49: step = mk(OP_TWO, 8'hB8, 16'h8002);
      6'd50: step = mk(OP_CMD, 8'h10, 16'h0000);
      6'd51: step = mk(OP_ONE, 8'hB0, 16'h0000);
      default: step = mk(OP_END, 8'h00, 16'h0000);
    endcase
  end

endmodule

// File: rtl/pps_timer.sv
module pps_timer #(
  parameter int unsigned CYCLES = 1
)(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);

  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] START = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? START : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned DELAY_US = 1000
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_req,
  input  logic        dis_req,
  input  logic        wr_done,
  input  logic        wr_err,
  output logic        wr_valid,
  output logic [1:0]  wr_kind,
  output logic [7:0]  wr_reg,
  output logic [15:0] wr_data,
  output logic        busy,
  output logic [1:0]  pnl_state
);

  localparam int unsigned CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int unsigned RAW_DLY    = CYC_PER_US * DELAY_US;
  localparam int unsigned DLY_CYC    = (RAW_DLY == 0) ? 1 : RAW_DLY;
  localparam logic [ROM_AW-1:0] PC_UP    = ROM_AW'(UP_BASE);
  localparam logic [ROM_AW-1:0] PC_DOWN  = ROM_AW'(DOWN_BASE);
  localparam logic [ROM_AW-1:0] OPEN_LIM = ROM_AW'(OPEN_STEPS);

  // reset: asserted at once, released through two flops
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  seq_e              sq_q, sq_d;
  logic [ROM_AW-1:0] pc_q, pc_d;
  logic              pc_en;
  logic              up_q, up_d;
  logic              err_q, err_d;
  pnl_state_e        pnl_q, pnl_d;
  step_t             cur;
  logic              tmr_load, tmr_exp;

  pps_rom #(.AW(ROM_AW)) u_rom (
    .addr (pc_q),
    .step (cur)
  );

  pps_timer #(.CYCLES(DLY_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .load    (tmr_load),
    .expired (tmr_exp)
  );

  always_comb begin
    sq_d     = sq_q;
    pc_d     = pc_q;
    pc_en    = 1'b0;
    up_d     = up_q;
    err_d    = err_q;
    pnl_d    = pnl_q;
    tmr_load = 1'b0;
    case (sq_q)
      SQ_IDLE: begin
        if (en_req && (pnl_q != PNL_ACTIVE)) begin
          sq_d  = SQ_RUN;
          pc_d  = PC_UP;
          pc_en = 1'b1;
          up_d  = 1'b1;
          err_d = 1'b0;
          pnl_d = PNL_INIT;
        end else if (dis_req && (pnl_q != PNL_OFF)) begin
          sq_d  = SQ_RUN;
          pc_d  = PC_DOWN;
          pc_en = 1'b1;
          up_d  = 1'b0;
        end
      end
      SQ_RUN: begin
        case (cur.op)
          OP_END: begin
            sq_d  = SQ_IDLE;
            pnl_d = !up_q ? PNL_OFF : (err_q ? PNL_ERROR : PNL_ACTIVE);
          end
          OP_DLY: begin
            tmr_load = 1'b1;
            sq_d     = SQ_DLY;
          end
          default: sq_d = SQ_WR;
        endcase
      end
      SQ_WR: begin
        if (wr_done) begin
          if (wr_err && up_q && (pc_q < OPEN_LIM)) begin
            sq_d  = SQ_IDLE;
            pnl_d = PNL_ERROR;
          end else begin
            if (wr_err && up_q) err_d = 1'b1;
            pc_d  = pc_q + 1'b1;
            pc_en = 1'b1;
            sq_d  = SQ_RUN;
          end
        end
      end
      SQ_DLY: begin
        if (tmr_exp) begin
          pc_d  = pc_q + 1'b1;
          pc_en = 1'b1;
          sq_d  = SQ_RUN;
        end
      end
      default: sq_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      sq_q  <= SQ_IDLE;
      pc_q  <= '0;
      up_q  <= 1'b0;
      err_q <= 1'b0;
      pnl_q <= PNL_OFF;
    end else begin
      sq_q  <= sq_d;
      if (pc_en) pc_q <= pc_d;
      up_q  <= up_d;
      err_q <= err_d;
      pnl_q <= pnl_d;
    end
  end

  always_comb begin
    case (cur.op)
      OP_ONE:  wr_kind = WK_ONE;
      OP_TWO:  wr_kind = WK_TWO;
      default: wr_kind = WK_CMD;
    endcase
  end

  assign wr_valid  = (sq_q == SQ_WR);
  assign wr_reg    = cur.reg_a;
  assign wr_data   = cur.val;
  assign busy      = (sq_q != SQ_IDLE);
  assign pnl_state = pnl_q;

endmodule

// File: rtl/pps_chk.sv
module pps_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en_req,
  input logic        dis_req,
  input logic        wr_done,
  input logic        wr_err,
  input logic        wr_valid,
  input logic [1:0]  wr_kind,
  input logic [7:0]  wr_reg,
  input logic [15:0] wr_data,
  input logic        busy,
  input logic [1:0]  pnl_state
);

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_done) |=> (wr_valid && $stable(wr_kind) && $stable(wr_reg) && $stable(wr_data)));

  a_r9_req_in_script: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy);

  a_r10_init_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (pnl_state == 2'd1) |-> busy);

  a_r8_ignore_en: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && en_req && !dis_req && pnl_state == 2'd2) |=> !busy);

  a_r8_ignore_dis: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && dis_req && !en_req && pnl_state == 2'd0) |=> !busy);

  a_r5_active_after_on: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pnl_state == 2'd2) |-> ($past(wr_done, 2) && !$past(wr_err, 2) && $past(wr_reg, 2) == 8'h29));

  a_r3_error_halts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pnl_state == 2'd3) |-> (!busy && !wr_valid));

endmodule

bind panel_pwr_seq pps_chk u_pps_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_req    (en_req),
  .dis_req   (dis_req),
  .wr_done   (wr_done),
  .wr_err    (wr_err),
  .wr_valid  (wr_valid),
  .wr_kind   (wr_kind),
  .wr_reg    (wr_reg),
  .wr_data   (wr_data),
  .busy      (busy),
  .pnl_state (pnl_state)
);

// File: tb/test_panel_pwr_seq.sv
module test_panel_pwr_seq;

  localparam int unsigned CLK_HZ   = 100_000_000;
  localparam int unsigned DELAY_US = 5;
  localparam int EXP_GAP = 500;   // 100 cycles per us * 5 us
  localparam int LAT     = 3;
  localparam int WD_LIM  = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_req = 1'b0;
  logic        dis_req = 1'b0;
  logic        wr_done = 1'b0;
  logic        wr_err = 1'b0;
  logic        wr_valid;
  logic [1:0]  wr_kind;
  logic [7:0]  wr_reg;
  logic [15:0] wr_data;
  logic        busy;
  logic [1:0]  pnl_state;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  int nw = 0;
  int nrise = 0;
  int fail_idx = -1;
  int lat_cnt = 0;
  logic vprev = 1'b0;
  logic [1:0]  lk [64];
  logic [7:0]  lr [64];
  logic [15:0] ld [64];
  int vstart [64];
  int dcyc [64];

  panel_pwr_seq #(.CLK_HZ(CLK_HZ), .DELAY_US(DELAY_US)) i_panel_pwr_seq (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
    .wr_done(wr_done), .wr_err(wr_err), .wr_valid(wr_valid),
    .wr_kind(wr_kind), .wr_reg(wr_reg), .wr_data(wr_data),
    .busy(busy), .pnl_state(pnl_state)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // writer model: answers a pending request after LAT cycles
  always @(negedge clk) begin
    if (wr_done) begin
      wr_done = 1'b0;
      wr_err  = 1'b0;
    end else if (wr_valid) begin
      if (!vprev) begin
        if (nrise < 64) vstart[nrise] = cyc;
        nrise = nrise + 1;
      end
      if (lat_cnt == LAT) begin
        if (nw < 64) begin
          lk[nw] = wr_kind; lr[nw] = wr_reg; ld[nw] = wr_data; dcyc[nw] = cyc;
        end
        wr_err  = (nw == fail_idx);
        wr_done = 1'b1;
        nw      = nw + 1;
        lat_cnt = 0;
      end else begin
        lat_cnt = lat_cnt + 1;
      end
    end
    vprev = wr_valid;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_wr(input int i, input logic [1:0] k, input logic [7:0] r, input logic [15:0] d, input string req);
    chk(lk[i] == k, req, $sformatf("write %0d kind", i), int'(lk[i]), int'(k));
    chk(lr[i] == r, req, $sformatf("write %0d reg", i), int'(lr[i]), int'(r));
    chk(ld[i] == d, req, $sformatf("write %0d data", i), int'(ld[i]), int'(d));
  endtask

  task automatic clr_log(input int fidx);
    nw = 0; nrise = 0; fail_idx = fidx;
  endtask

  task automatic pulse(input bit up);
    @(negedge clk);
    if (up) en_req = 1'b1; else dis_req = 1'b1;
    @(negedge clk);
    en_req = 1'b0; dis_req = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(pnl_state == 2'd0, "R1", "state after reset", int'(pnl_state), 0);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(wr_valid == 1'b0, "R1", "wr_valid after reset", int'(wr_valid), 0);
  endtask

  task automatic t_up_ok();
    clr_log(-1);
    pulse(1'b1);
    chk(pnl_state == 2'd1, "R10", "state during power-up", int'(pnl_state), 1);
    chk(busy == 1'b1, "R10", "busy during power-up", int'(busy), 1);
    wait_idle();
    for (int i = 0; i < 3; i++) begin
      chk_wr(i, 2'd0, 8'h00, 16'h0000, "R2");
      chk(vstart[i+1] - dcyc[i] >= EXP_GAP, "R2", $sformatf("pause after opening %0d", i),
          vstart[i+1] - dcyc[i], EXP_GAP);
    end
    chk_wr(3, 2'd1, 8'hB0, 16'h0017, "R4");
    chk_wr(4, 2'd1, 8'hBC, 16'h0080, "R4");
    chk_wr(5, 2'd1, 8'h3B, 16'h0000, "R4");
    chk_wr(6, 2'd1, 8'hB0, 16'h0016, "R4");
    chk_wr(7, 2'd2, 8'hB8, 16'hFFF9, "R4");
    chk_wr(8, 2'd0, 8'h11, 16'h0000, "R4");
    chk(nw == 44, "R5", "power-up write count", nw, 44);
    chk_wr(43, 2'd0, 8'h29, 16'h0000, "R5");
    chk(pnl_state == 2'd2, "R5", "state after power-up", int'(pnl_state), 2);
    chk(nrise == nw, "R9", "requests vs strobes", nrise, nw);
  endtask

  task automatic t_ign_en();
    clr_log(-1);
    pulse(1'b1);
    repeat (5) @(negedge clk);
    chk(nw == 0 && busy == 1'b0, "R8", "enable while active writes", nw, 0);
    chk(pnl_state == 2'd2, "R8", "state after ignored enable", int'(pnl_state), 2);
  endtask

  task automatic t_down();
    clr_log(-1);
    pulse(1'b0);
    wait_idle();
    chk(nw == 4, "R7", "power-down write count", nw, 4);
    chk_wr(0, 2'd0, 8'h28, 16'h0000, "R7");
    chk_wr(1, 2'd2, 8'hB8, 16'h8002, "R7");
    chk_wr(2, 2'd0, 8'h10, 16'h0000, "R7");
    chk_wr(3, 2'd1, 8'hB0, 16'h0000, "R7");
    chk(pnl_state == 2'd0, "R7", "state after power-down", int'(pnl_state), 0);
  endtask

  task automatic t_ign_dis();
    clr_log(-1);
    pulse(1'b0);
    repeat (5) @(negedge clk);
    chk(nw == 0 && busy == 1'b0, "R8", "disable while off writes", nw, 0);
    chk(pnl_state == 2'd0, "R8", "state after ignored disable", int'(pnl_state), 0);
  endtask

  task automatic t_abort();
    clr_log(1);
    pulse(1'b1);
    wait_idle();
    repeat (EXP_GAP + 20) @(negedge clk);
    chk(nw == 2, "R3", "writes after opening failure", nw, 2);
    chk(pnl_state == 2'd3, "R3", "state after opening failure", int'(pnl_state), 3);
  endtask

  task automatic t_late_err();
    clr_log(10);
    pulse(1'b1);
    wait_idle();
    chk(nw == 44, "R6", "writes with late failure", nw, 44);
    chk_wr(43, 2'd0, 8'h29, 16'h0000, "R6");
    chk(pnl_state == 2'd3, "R6", "state with late failure", int'(pnl_state), 3);
  endtask

  task automatic t_busy_ign();
    clr_log(-1);
    pulse(1'b1);
    repeat (100) @(negedge clk);
    pulse(1'b0);
    pulse(1'b1);
    wait_idle();
    chk(nw == 44, "R8", "requests while busy change count", nw, 44);
    chk(pnl_state == 2'd2, "R8", "state after busy requests", int'(pnl_state), 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_up_ok();
    t_ign_en();
    t_down();
    t_ign_dis();
    t_abort();
    t_late_err();
    t_down();
    t_busy_ign();
    t_down();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (WD_LIM) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule